// File: doc/BRIEF.md
# Transmit DMA Hang Signature Matcher

This block decides whether a transmit DMA and queue engine is stuck in one of two known deadlock states. It watches four 32-bit debug status words: a queue-state word, two chain-state words and a completion word. A start request takes a snapshot of all four words. The block then compares a fixed number of further samples against that snapshot, one sample per clock cycle. The engine counts as frozen only if every sample equals the snapshot.

A frozen snapshot is tested against two state signatures. Signature 1 looks for a chain-state code in any of ten 5-bit slots spread over the two chain words, together with a completion code. Signature 2 checks three queue fields at once. Signature 1 is tested first. The outcome is reported on a 2-bit result together with a one-cycle done pulse, and the result holds until the next check finishes. Whatever supplies the debug words, and whatever recovery follows a hang, lies outside this block.

Top module: `dma_hang_detect`

## Requirements
- R1: After reset, done_o is 0 and result_o is 0 (none).
- R2: When start_i is high while the block is idle, the four words are captured at that clock edge. If the next NUM_READS (default 50) samples all equal the capture, done_o rises at the NUM_READS-th edge after the capture edge.
- R3: If any bit of any word differs from the capture in the k-th sample (1 ≤ k ≤ NUM_READS), done_o rises at the k-th edge after capture and result_o is 0 (none), whatever the words contain.
- R4: Signature 1 (result 1) is met when some 5-bit slot i (i = 0..5, bits [5i+4:5i]) of chain_word_a_i equals 6 and complete_word_i[1:0] equals 1.
- R5: Signature 1 is also met through chain_word_b_i slots i = 0..3 (bits [5i+4:5i]). A code of 6 that is not aligned to a slot, or that sits above bit 19 of chain_word_b_i, does not count.
- R6: Without complete_word_i[1:0] equal to 1, a chain-state match alone gives result 0.
- R7: Signature 2 (result 2) is met when queue_word_i[21:18] is 9, queue_word_i[25:22] is 8 and queue_word_i[28:26] is 4. If any one of these fields differs, signature 2 is not met.
- R8: When both signatures are met, the result is 1.
- R9: Stable words that meet neither signature give result 0.
- R10: A start_i pulse while a check is in progress is ignored. The running check keeps its capture and its timing.
- R11: done_o is high for exactly one cycle. result_o never takes the value 3 and holds its value until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a check; honoured only when idle |
| queue_word_i | input | 32 | Queue-state debug word (signature 2 fields) |
| chain_word_a_i | input | 32 | Chain-state debug word, six 5-bit slots |
| chain_word_b_i | input | 32 | Chain-state debug word, four 5-bit slots |
| complete_word_i | input | 32 | Completion-state debug word, bits [1:0] used |
| done_o | output | 1 | One-cycle pulse when a check finishes |
| result_o | output | 2 | 0 none, 1 signature 1, 2 signature 2 |

## Verification
A corrupted capture register or a miscounted window shows up at the ports on the very check it affects. With a bad capture, stable input reads as unstable, so done arrives at the first sample with result 0. With a miscounted window, done arrives earlier or later than NUM_READS edges after start. The bench measures the done cycle exactly, so an off-by-one window is caught. A wrong slot decode or a wrong priority leaves the timing intact but gives a wrong result code, and that code is checked against words built so that one field or slot is the only deciding factor. A stuck state machine appears as a missing done pulse, or as a start during a check that changes the finish cycle.

// File: rtl/dbg_hang_pkg.sv
// Package: shared types and constants for the DMA hang signature matcher.
// Assumes all debug words share one width; field positions are fixed.
package dbg_hang_pkg;

    localparam int DBG_W = 32;

    // Result encoding reported on the top-level result port
    typedef enum logic [1:0] {
        HANG_NONE = 2'd0,
        HANG_SIG1 = 2'd1,
        HANG_SIG2 = 2'd2
    } hang_code_e;

    // Bundle of the four debug status words
    typedef struct packed {
        logic [DBG_W-1:0] queue;
        logic [DBG_W-1:0] chain_a;
        logic [DBG_W-1:0] chain_b;
        logic [DBG_W-1:0] complete;
    } dbg_words_t;

    // Controller states
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WATCH = 1'b1
    } watch_state_e;

endpackage

// File: rtl/hang_stability_tracker.sv
// Module: hang_stability_tracker
// Holds a snapshot of the debug words and compares one live sample per
// cycle against it while compare_i is high. Flags a mismatch at once and
// flags window completion on the NUM_READS-th equal sample.
// Assumes capture_i and compare_i are never high together.
module hang_stability_tracker
    import dbg_hang_pkg::*;
#(
    parameter int NUM_READS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  logic       compare_i,
    input  dbg_words_t words_i,
    output dbg_words_t snap_o,
    output logic       mismatch_o,
    output logic       window_full_o
);

    localparam int CNT_W = $clog2(NUM_READS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_READS - 1);

    dbg_words_t       snap_q;
    logic [CNT_W-1:0] cnt_q;
    logic             equal_now;

    // Purpose: compare the live sample with the snapshot
    always_comb begin
        equal_now     = (words_i == snap_q);
        mismatch_o    = compare_i && !equal_now;
        window_full_o = compare_i && equal_now && (cnt_q == LAST_CNT);
    end

    // Purpose: load the snapshot on capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture_i) begin
            snap_q <= words_i;
        end
    end

    // Purpose: count equal samples since the capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (capture_i) begin
            cnt_q <= '0;
        end else if (compare_i && equal_now) begin
            if (cnt_q == LAST_CNT) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign snap_o = snap_q;

    // The snapshot may not move during the compare window (R10)
    assert_snap_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (compare_i && !capture_i) |=> $stable(snap_q));

    // The sample counter never passes the window length (R2)
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // Mismatch and window completion are exclusive (R3)
    assert_excl_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mismatch_o && window_full_o));

endmodule

// File: rtl/hang_signature_matcher.sv
// Module: hang_signature_matcher
// Tests the frozen snapshot against the two hang signatures.
// Signature 1: a chain code in any slot of the two chain words plus a
// completion code. Signature 2: three fixed queue fields.
// Purely combinational; the caller applies the priority.
module hang_signature_matcher
    import dbg_hang_pkg::*;
#(
    parameter int FIELD_W       = 5,
    parameter int SLOTS_A       = 6,
    parameter int SLOTS_B       = 4,
    parameter int CHAIN_CODE    = 6,
    parameter int COMPLETE_W    = 2,
    parameter int COMPLETE_CODE = 1,
    parameter int STITCH_LSB    = 18,
    parameter int STITCH_W      = 4,
    parameter int STITCH_CODE   = 9,
    parameter int FETCH_LSB     = 22,
    parameter int FETCH_W       = 4,
    parameter int FETCH_CODE    = 8,
    parameter int FINISH_LSB    = 26,
    parameter int FINISH_W      = 3,
    parameter int FINISH_CODE   = 4
) (
    input  dbg_words_t words_i,
    output logic       sig1_o,
    output logic       sig2_o
);

    localparam logic [FIELD_W-1:0]    CHAIN_V    = FIELD_W'(CHAIN_CODE);
    localparam logic [COMPLETE_W-1:0] COMPLETE_V = COMPLETE_W'(COMPLETE_CODE);
    localparam logic [STITCH_W-1:0]   STITCH_V   = STITCH_W'(STITCH_CODE);
    localparam logic [FETCH_W-1:0]    FETCH_V    = FETCH_W'(FETCH_CODE);
    localparam logic [FINISH_W-1:0]   FINISH_V   = FINISH_W'(FINISH_CODE);

    logic [SLOTS_A-1:0] hit_a;
    logic [SLOTS_B-1:0] hit_b;

    // Slot comparators on the first chain word
    for (genvar i = 0; i < SLOTS_A; i++) begin : g_slot_a
        assign hit_a[i] = (words_i.chain_a[i*FIELD_W +: FIELD_W] == CHAIN_V);
    end

    // Slot comparators on the second chain word
    for (genvar j = 0; j < SLOTS_B; j++) begin : g_slot_b
        assign hit_b[j] = (words_i.chain_b[j*FIELD_W +: FIELD_W] == CHAIN_V);
    end

    // Purpose: combine slot hits and field checks into the two signatures
    always_comb begin
        sig1_o = ((|hit_a) || (|hit_b)) &&
                 (words_i.complete[COMPLETE_W-1:0] == COMPLETE_V);
        sig2_o = (words_i.queue[STITCH_LSB +: STITCH_W] == STITCH_V) &&
                 (words_i.queue[FETCH_LSB  +: FETCH_W]  == FETCH_V)  &&
                 (words_i.queue[FINISH_LSB +: FINISH_W] == FINISH_V);
    end

endmodule

// File: rtl/dma_hang_detect.sv
// Module: dma_hang_detect (top)
// Runs one hang check per accepted start: capture, a stability window of
// NUM_READS samples, then a signature test with signature 1 first.
// Reports through a one-cycle done pulse and a held 2-bit result.
// Assumes the debug words are synchronous to clk.
module dma_hang_detect
    import dbg_hang_pkg::*;
#(
    parameter int NUM_READS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DBG_W-1:0] queue_word_i,
    input  logic [DBG_W-1:0] chain_word_a_i,
    input  logic [DBG_W-1:0] chain_word_b_i,
    input  logic [DBG_W-1:0] complete_word_i,
    output logic             done_o,
    output logic [1:0]       result_o
);

    watch_state_e state_q;
    dbg_words_t   live_words;
    dbg_words_t   snap_words;
    logic         capture;
    logic         compare;
    logic         mismatch;
    logic         window_full;
    logic         sig1;
    logic         sig2;
    logic         done_q;
    hang_code_e   result_q;
    hang_code_e   verdict;

    // Purpose: bundle the live inputs and derive the tracker controls
    always_comb begin
        live_words.queue    = queue_word_i;
        live_words.chain_a  = chain_word_a_i;
        live_words.chain_b  = chain_word_b_i;
        live_words.complete = complete_word_i;
        capture = (state_q == ST_IDLE) && start_i;
        compare = (state_q == ST_WATCH);
    end

    hang_stability_tracker #(
        .NUM_READS (NUM_READS)
    ) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_i     (capture),
        .compare_i     (compare),
        .words_i       (live_words),
        .snap_o        (snap_words),
        .mismatch_o    (mismatch),
        .window_full_o (window_full)
    );

    hang_signature_matcher u_matcher (
        .words_i (snap_words),
        .sig1_o  (sig1),
        .sig2_o  (sig2)
    );

    // Purpose: pick the verdict with signature 1 ahead of signature 2
    always_comb begin
        if (sig1) begin
            verdict = HANG_SIG1;
        end else if (sig2) begin
            verdict = HANG_SIG2;
        end else begin
            verdict = HANG_NONE;
        end
    end

    // Purpose: sequence idle and watch, issue done and the held result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b0;
            result_q <= HANG_NONE;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_WATCH;
                    end
                end
                ST_WATCH: begin
                    if (mismatch) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        result_q <= HANG_NONE;
                    end else if (window_full) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        result_q <= verdict;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

    // Done lasts exactly one cycle (R11)
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // The result code stays within the three legal values (R11)
    assert_result_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        result_q != 2'd3);

    // The result only changes together with done (R11)
    assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(result_q) || $rose(done_q));

    // An unstable sample ends the check with no hang (R3)
    assert_abort_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (done_q && result_q == HANG_NONE));

    // Signature 1 wins when both signatures are met (R8)
    assert_sig1_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (window_full && sig1 && sig2) |=> (result_q == HANG_SIG1));

    // A start while watching does not disturb the check (R10)
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (compare && start_i && !mismatch && !window_full) |=>
            (state_q == ST_WATCH && !done_q));

endmodule

// File: tb/dma_hang_detect_bench.sv
module dma_hang_detect_bench;

    localparam int N_READS = 50;

    logic        clk;
    logic        rst_n;
    logic        start_i;
    logic [31:0] queue_word_i;
    logic [31:0] chain_word_a_i;
    logic [31:0] chain_word_b_i;
    logic [31:0] complete_word_i;
    logic        done_o;
    logic [1:0]  result_o;

    int errors = 0;
    int checks = 0;

    localparam logic [31:0] SIG2_Q = 32'h1224_0000;

    dma_hang_detect #(.NUM_READS(N_READS)) u_dma_hang_detect (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .queue_word_i    (queue_word_i),
        .chain_word_a_i  (chain_word_a_i),
        .chain_word_b_i  (chain_word_b_i),
        .complete_word_i (complete_word_i),
        .done_o          (done_o),
        .result_o        (result_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full check: words, optional disturbance at sample flip_at,
    // optional extra start at sample restart_at, expected finish and code.
    task automatic run_check(input logic [31:0] q, input logic [31:0] a,
                             input logic [31:0] b, input logic [31:0] c,
                             input int flip_at, input int restart_at,
                             input int exp_cyc, input int exp_res,
                             input string req);
        int got_cyc;
        got_cyc = -1;
        @(negedge clk);
        queue_word_i = q; chain_word_a_i = a; chain_word_b_i = b; complete_word_i = c;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= N_READS + 10; i++) begin
            if (i == flip_at) queue_word_i = queue_word_i ^ 32'h8000_0000;
            start_i = (i == restart_at);
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) begin
                got_cyc = i;
                break;
            end
        end
        chk(got_cyc == exp_cyc, {req, " done cycle"}, got_cyc, exp_cyc);
        chk(result_o == 2'(exp_res), {req, " result"}, int'(result_o), exp_res);
        @(negedge clk);
        chk(done_o == 1'b0, "R11 done single cycle", int'(done_o), 0);
        chk(result_o == 2'(exp_res), "R11 result held", int'(result_o), exp_res);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; start_i = 1'b0;
        queue_word_i = '0; chain_word_a_i = '0; chain_word_b_i = '0; complete_word_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        chk(result_o == 2'd0, "R1 result after reset", int'(result_o), 0);
    endtask

    task automatic test_chain_a();
        run_check(32'h0, 32'd6, 32'h0, 32'h1, 0, 0, N_READS, 1, "R2 R4 slot a0");
        run_check(32'h0, 32'd6 << 25, 32'h0, 32'h1, 0, 0, N_READS, 1, "R4 slot a5");
    endtask

    task automatic test_chain_b();
        run_check(32'h0, 32'h0, 32'd6 << 15, 32'h1, 0, 0, N_READS, 1, "R5 slot b3");
        run_check(32'h0, 32'd6 << 1, 32'd6 << 20, 32'h1, 0, 0, N_READS, 0, "R5 unaligned");
    endtask

    task automatic test_no_complete();
        run_check(32'h0, 32'd6 << 10, 32'h0, 32'h3, 0, 0, N_READS, 0, "R6 no completion");
    endtask

    task automatic test_sig2();
        run_check(SIG2_Q, 32'h0, 32'h0, 32'h0, 0, 0, N_READS, 2, "R7 sig2");
        run_check(SIG2_Q ^ (32'h1 << 26), 32'h0, 32'h0, 32'h0, 0, 0, N_READS, 0, "R7 field off");
    endtask

    task automatic test_priority();
        run_check(SIG2_Q, 32'd6 << 5, 32'h0, 32'h1, 0, 0, N_READS, 1, "R8 both");
    endtask

    task automatic test_nomatch();
        run_check(32'h0, 32'h1F_FFFF, 32'h0, 32'h2, 0, 0, N_READS, 0, "R9 stable none");
    endtask

    task automatic test_unstable();
        run_check(SIG2_Q, 32'd6, 32'h0, 32'h1, 1, 0, 1, 0, "R3 first sample");
        run_check(SIG2_Q, 32'd6, 32'h0, 32'h1, N_READS, 0, N_READS, 0, "R3 last sample");
    endtask

    task automatic test_restart();
        run_check(SIG2_Q, 32'h0, 32'h0, 32'h0, 0, 20, N_READS, 2, "R10 start ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_chain_a();
        test_chain_b();
        test_no_complete();
        test_sig2();
        test_priority();
        test_nomatch();
        test_unstable();
        test_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule